// File: doc/BRIEF.md
# Two-Operand Integer Calculator Sequencer

This block is the arithmetic stage of a small keypad calculator. A 16-bit unsigned operand bus is shared by five single-bit request lines: four operation requests (add, subtract, multiply, divide) and one equals request. An operation request latches the bus value as the left operand and records which operation was chosen. An equals request latches the bus value as the right operand. On the next clock the block computes a 32-bit unsigned result and stores it in a register.

After the result register loads, the block waits one clock and then raises a ready interrupt for a fixed number of clocks, two by default. Every request line goes through rising-edge detection, so a request held high for many clocks acts only once. A display or host stage watches the interrupt and reads the result while it is high.

Top module: `calc_seq_top`

## Requirements
- R1: On the clock edge where an operation request (`req_add`, `req_sub`, `req_mul`, `req_div`) is first sampled high, the value on `operand_in` is stored as the left operand and that operation is recorded.
- R2: On the clock edge where `req_eq` is first sampled high, `operand_in` is stored as the right operand, and `result` shows the new value after the next clock edge.
- R3: `irq` goes high one clock after the result register loads and stays high for exactly IRQ_CYCLES (2) consecutive clocks. It is low at all other times.
- R4: Each request acts only on its rising edge. A request held high for many clocks causes one capture, and changes on `operand_in` while it stays high are ignored.
- R5: Add and multiply treat both operands as unsigned, zero-extended to 32 bits. For example 0xFFFF*0xFFFF gives 0xFFFE0001 and 0xFFFF+0xFFFF gives 0x0001FFFE.
- R6: Subtract returns the 32-bit two's-complement wraparound of left minus right. For example 3-5 gives 0xFFFFFFFE.
- R7: Divide returns the truncated integer quotient. A zero divisor returns 0xFFFFFFFF.
- R8: At most one operation is recorded at a time. A later request replaces the earlier one. When several operation requests rise on the same clock, priority is add, then subtract, then multiply, then divide.
- R9: Synchronous reset `rst` clears both operands, the recorded operation, the result and the interrupt, and drops any computation in flight. An equals request with no operation recorded loads a result of zero.
- R10: An operation request that rises in the same cycle as the result load does not affect that result. The result uses the earlier operands and operation, and the new request is taken for the next calculation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand_in | input | 16 | Unsigned operand bus |
| req_add | input | 1 | Add request |
| req_sub | input | 1 | Subtract request |
| req_mul | input | 1 | Multiply request |
| req_div | input | 1 | Divide request |
| req_eq | input | 1 | Equals request; captures the right operand |
| result | output | 32 | Registered arithmetic result |
| irq | output | 1 | Result-ready interrupt pulse |

## Verification
The clash that matters is an operation request rising in the same cycle as the result register loads for the previous equals. The bench raises `req_mul` with a new operand right after the equals edge. It then checks that the loaded result still comes from the earlier subtraction, and that the following equals produces the product. A second overlap is several operation requests rising on one edge; the bench judges it by which operation the next result reflects.

// File: rtl/calc_pkg.sv
package calc_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_DIV = 2'd3
  } calc_op_e;

  localparam int NUM_OPS = 4;
  localparam int NUM_REQ = NUM_OPS + 1;
  localparam int EQ_IDX  = NUM_OPS;
endpackage

// File: rtl/calc_rise_det.sv
module calc_rise_det #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_once
      AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (rst)
        rise[i] |=> !rise[i]); // R4
    end
  endgenerate
endmodule

// File: rtl/calc_opnd_reg.sv
module calc_opnd_reg
  import calc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OPS-1:0] op_rise,
  input  logic               eq_rise,
  input  logic [DW-1:0]      din,
  output logic [DW-1:0]      opa,
  output logic [DW-1:0]      opb,
  output logic [NUM_OPS-1:0] flags
);
  logic [NUM_OPS-1:0] pick;

  // lowest index wins: add, sub, mul, div
  always_comb begin
    pick = '0;
    for (int i = NUM_OPS - 1; i >= 0; i--) begin
      if (op_rise[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opa   <= '0;
      opb   <= '0;
      flags <= '0;
    end else begin
      if (|op_rise) begin
        opa   <= din;
        flags <= pick;
      end
      if (eq_rise) opb <= din;
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flags)); // R8
  AST_OPA_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (|op_rise) |=> (opa == $past(din))); // R1
  AST_OPB_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    eq_rise |=> (opb == $past(din))); // R2
endmodule

// File: rtl/calc_arith.sv
module calc_arith
  import calc_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 2 * DW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [DW-1:0]      a,
  input  logic [DW-1:0]      b,
  input  logic [NUM_OPS-1:0] flags,
  output logic [RW-1:0]      y
);
  logic [RW-1:0] a_x, b_x, nxt;

  assign a_x = RW'(a);
  assign b_x = RW'(b);

  always_comb begin
    nxt = '0;
    if (flags[OP_ADD])      nxt = a_x + b_x;
    else if (flags[OP_SUB]) nxt = a_x - b_x;
    else if (flags[OP_MUL]) nxt = a_x * b_x;
    else if (flags[OP_DIV]) nxt = (b == '0) ? '1 : RW'(a / b);
  end

  always_ff @(posedge clk) begin
    if (rst)       y <= '0;
    else if (load) y <= nxt;
  end

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(y)); // R2
endmodule

// File: rtl/calc_irq_pulse.sv
module calc_irq_pulse #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  output logic irq
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic          start_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      cnt_q   <= '0;
      irq     <= 1'b0;
    end else begin
      start_q <= ld;
      if (start_q) begin
        irq   <= 1'b1;
        cnt_q <= CW'(LEN - 1);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        irq <= 1'b0;
      end
    end
  end

  // checker counter: cycles irq has been high since the last start
  logic [CW:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst)          hi_run <= '0;
    else if (start_q) hi_run <= '0;
    else if (irq && hi_run != '1) hi_run <= hi_run + 1'b1;
    else if (!irq)    hi_run <= '0;
  end

  AST_IRQ_WIDTH: assert property (@(posedge clk) disable iff (rst)
    irq |-> (hi_run < (CW+1)'(LEN))); // R3
  AST_IRQ_START: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(ld, 2)); // R3
endmodule

// File: rtl/calc_seq_top.sv
module calc_seq_top
  import calc_pkg::*;
#(
  parameter int DW         = 16,
  parameter int RW         = 2 * DW,
  parameter int IRQ_CYCLES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [15:0]   operand_in,
  input  logic          req_add,
  input  logic          req_sub,
  input  logic          req_mul,
  input  logic          req_div,
  input  logic          req_eq,
  output logic [31:0]   result,
  output logic          irq
);
  logic [NUM_REQ-1:0] req_lvl, req_rise;
  logic [DW-1:0]      opa, opb;
  logic [NUM_OPS-1:0] flags;
  logic               ld_q;
  logic [RW-1:0]      res_w;

  assign req_lvl = {req_eq, req_div, req_mul, req_sub, req_add};

  calc_rise_det #(.W(NUM_REQ)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (req_lvl),
    .rise (req_rise)
  );

  calc_opnd_reg #(.DW(DW)) u_opnd (
    .clk     (clk),
    .rst     (rst),
    .op_rise (req_rise[NUM_OPS-1:0]),
    .eq_rise (req_rise[EQ_IDX]),
    .din     (DW'(operand_in)),
    .opa     (opa),
    .opb     (opb),
    .flags   (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) ld_q <= 1'b0;
    else     ld_q <= req_rise[EQ_IDX];
  end

  calc_arith #(.DW(DW), .RW(RW)) u_arith (
    .clk   (clk),
    .rst   (rst),
    .load  (ld_q),
    .a     (opa),
    .b     (opb),
    .flags (flags),
    .y     (res_w)
  );

  calc_irq_pulse #(.LEN(IRQ_CYCLES)) u_irq (
    .clk (clk),
    .rst (rst),
    .ld  (ld_q),
    .irq (irq)
  );

  assign result = 32'(res_w);

  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ld_q && flags[OP_DIV] && opb == '0) |=> (result == '1)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (result == '0 && !irq)); // R9
endmodule

// File: tb/sim_calc_seq_top.sv
`timescale 1ns/1ps
module sim_calc_seq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] operand_in = '0;
  logic        req_add = 0, req_sub = 0, req_mul = 0, req_div = 0, req_eq = 0;
  logic [31:0] result;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;

  calc_seq_top u0 (
    .clk(clk), .rst(rst), .operand_in(operand_in),
    .req_add(req_add), .req_sub(req_sub), .req_mul(req_mul),
    .req_div(req_div), .req_eq(req_eq), .result(result), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected results on each irq rise and times the pulse
  logic irq_prev = 1'b0;
  int   run = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (irq && !irq_prev) begin
        pulses++;
        run = 1;
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected irq", result, '0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(result == e, "R5/R6/R7 result at irq", result, e);
        end
      end else if (irq) begin
        run++;
      end else if (irq_prev) begin
        chk(run == 2, "R3 irq width", 32'(run), 32'd2);
      end
    end
    irq_prev = irq;
  end

  task automatic press_op(input int kind, input logic [15:0] v);
    @(negedge clk);
    operand_in = v;
    case (kind)
      0: req_add = 1; 1: req_sub = 1; 2: req_mul = 1; default: req_div = 1;
    endcase
    @(negedge clk);
    req_add = 0; req_sub = 0; req_mul = 0; req_div = 0;
  endtask

  task automatic press_eq(input logic [15:0] v, input logic [31:0] e, input bit push);
    @(negedge clk);
    operand_in = v;
    req_eq = 1;
    if (push) exp_q.push_back(e);
    @(negedge clk);
    req_eq = 0;
    chk(irq == 1'b0, "R3 irq low at capture", 32'(irq), 32'd0);
  endtask

  task automatic wait_result(input logic [31:0] e);
    @(negedge clk);
    chk(result == e, "R2 result one clock after equals", result, e);
    chk(irq == 1'b0, "R3 irq low at load", 32'(irq), 32'd0);
    req_add = 0; req_sub = 0; req_mul = 0; req_div = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic calc(input int kind, input logic [15:0] a, input logic [15:0] b,
                      input logic [31:0] e);
    press_op(kind, a);
    press_eq(b, e, 1'b1);
    wait_result(e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(result == 0, "R9 reset result", result, 0);
    chk(irq == 0, "R9 reset irq", 32'(irq), 0);
    rst = 0;

    calc(0, 16'd1234, 16'd4321, 32'd5555);            // R5 add
    calc(0, 16'hFFFF, 16'hFFFF, 32'h0001FFFE);        // R5 add carry
    calc(2, 16'hFFFF, 16'hFFFF, 32'hFFFE0001);        // R5 mul
    calc(1, 16'd3, 16'd5, 32'hFFFFFFFE);              // R6 wrap
    calc(1, 16'd900, 16'd100, 32'd800);               // R6
    calc(3, 16'd1000, 16'd7, 32'd142);                // R7 truncation
    calc(3, 16'd55, 16'd0, 32'hFFFFFFFF);             // R7 divide by zero

    // R1/R8: later op replaces earlier (add then div)
    press_op(0, 16'd77);
    press_op(3, 16'd80);
    press_eq(16'd8, 32'd10, 1'b1);
    wait_result(32'd10);

    // R8: simultaneous sub and mul, sub has priority
    @(negedge clk);
    operand_in = 16'd50; req_sub = 1; req_mul = 1;
    @(negedge clk);
    req_sub = 0; req_mul = 0;
    press_eq(16'd8, 32'd42, 1'b1);
    wait_result(32'd42);

    // R4: held add request, operand changes ignored
    @(negedge clk);
    operand_in = 16'd11; req_add = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      operand_in = 16'd500 + 16'(i);
    end
    req_add = 0;
    press_eq(16'd4, 32'd15, 1'b1);
    wait_result(32'd15);

    // R4: held equals gives a single pulse
    begin
      int p0;
      press_op(0, 16'd10);
      p0 = pulses;
      @(negedge clk);
      operand_in = 16'd20; req_eq = 1; exp_q.push_back(32'd30);
      repeat (8) @(negedge clk);
      operand_in = 16'd99;
      repeat (2) @(negedge clk);
      req_eq = 0;
      repeat (4) @(negedge clk);
      chk(pulses - p0 == 1, "R4 one pulse for held equals", 32'(pulses - p0), 1);
      chk(result == 32'd30, "R4 result unchanged by held equals", result, 32'd30);
    end

    // R10: mul request rises in the load cycle of a subtraction
    press_op(1, 16'd100);
    press_eq(16'd40, 32'd60, 1'b1);
    operand_in = 16'd6; req_mul = 1;
    wait_result(32'd60);
    press_eq(16'd7, 32'd42, 1'b1);
    wait_result(32'd42);

    // R9: reset drops a computation in flight and clears the operation
    press_op(2, 16'd9);
    press_eq(16'd9, 32'd81, 1'b0);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    chk(result == 0, "R9 result cleared", result, 0);
    chk(exp_q.size() == 0 && irq == 0, "R9 no irq after reset", 32'(irq), 0);
    press_eq(16'd123, 32'd0, 1'b1);
    wait_result(32'd0);

    chk(exp_q.size() == 0, "R3 all results reported", 32'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R3 actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule